// File: doc/BRIEF.md
# Timed Transmit Packet Scheduler

The scheduler sits between a transmit packet buffer and the sample output path. Each packet arrives as one header beat followed by a variable number of sample beats. The header holds a launch time, a carrier-sense request, a deadline in clock ticks and a sample count. A free-running 32-bit local time counter decides when a packet may start. A launch time of all ones means the packet goes as soon as possible.

A packet that requests carrier sense also waits until the received signal strength is below a threshold. Control writes set that threshold through a small register port, apart from the data path. A nonzero deadline limits the wait for a clear channel. When it runs out, the packet's samples are drained from the input and thrown away. A packet whose launch time has already passed when it is examined is thrown away in the same manner. Once the first sample has left, the rest of the packet follows without interruption.

The header, sample input and sample output ports are valid/ready streams. A beat moves on a clock edge where both valid and ready are high. Once valid is raised, the source must hold it and the beat's data until that edge. The header port is ready only when no packet is in progress. While a packet is being sent, sample input ready mirrors sample output ready, so back-pressure from downstream stalls the input. While a packet is being dropped, sample input ready is held high and nothing appears on the output. The RSSI input, the register port and the status pulses are plain signals.

Top module: `tx_launch_sched`

## Requirements
- R1: After a synchronous reset, `smp_out_valid` and all three status pulses are low and `hdr_ready` is high. `time_now` advances by exactly one every clock.
- R2: A header with `hdr_launch_at` equal to all ones and `hdr_chan_check` low is sent without a time wait. Its `hdr_count` samples appear in order, and `smp_out_last` is high only on the final one.
- R3: For a timed packet without carrier sense, if samples are waiting and the output is ready, the first sample is transferred in the cycle in which `time_now` equals `hdr_launch_at`.
- R4: A packet is late when, in the first cycle after its header is accepted, `time_now + 1` is already greater than `hdr_launch_at` (unsigned). A late packet is not sent, and `evt_late` pulses.
- R5: A write with `cfg_we` high and `cfg_addr` equal to 0 loads `cfg_wdata` into the RSSI threshold. Writes to any other address leave the threshold unchanged.
- R6: A packet with `hdr_chan_check` high starts only while `rssi` is strictly below the threshold. For a timed packet with a clear channel, the first sample is transferred when `time_now` equals `hdr_launch_at + 1`.
- R7: The deadline count starts once the time condition is met. If the channel stays busy for `hdr_deadline` cycles, with the value nonzero, the packet is dropped and `evt_expired` pulses in the cycle where `time_now` equals `hdr_launch_at + hdr_deadline`. A deadline of 0 waits without limit.
- R8: A dropped packet (late or expired) consumes exactly `hdr_count` samples from the input and presents none at the output, so the next header lines up with its own samples.
- R9: Once the first sample has been transferred, the whole packet is sent even if `rssi` rises above the threshold or the deadline passes.
- R10: While `smp_out_ready` is low during a send, no input sample is consumed, and no sample is lost or repeated.
- R11: `evt_sent` pulses for one cycle, in the cycle after the final sample is transferred. At most one status pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header beat valid |
| hdr_ready | output | 1 | Header accepted (no packet in progress) |
| hdr_launch_at | input | 32 | Launch time; all ones means immediate |
| hdr_chan_check | input | 1 | Wait for RSSI below threshold before starting |
| hdr_deadline | input | 16 | Ticks allowed for a clear channel; 0 means no limit |
| hdr_count | input | 12 | Sample count of the packet, must be nonzero |
| smp_in_valid | input | 1 | Input sample valid |
| smp_in_ready | output | 1 | Input sample taken |
| smp_in_data | input | 32 | Input sample |
| smp_out_valid | output | 1 | Output sample valid |
| smp_out_ready | input | 1 | Downstream accepts sample |
| smp_out_data | output | 32 | Output sample |
| smp_out_last | output | 1 | Final sample of the packet |
| rssi | input | 12 | Current received signal strength |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address; 0 is the threshold |
| cfg_wdata | input | 12 | Register write data |
| time_now | output | 32 | Local time counter |
| evt_sent | output | 1 | One-cycle pulse: packet fully sent |
| evt_expired | output | 1 | One-cycle pulse: dropped on deadline |
| evt_late | output | 1 | One-cycle pulse: dropped as late |

## Verification
The hardest case is the deadline expiry. It needs a channel that is busy throughout the window, a known start of the count, and samples already queued at the input so the drain can be observed. The stimulus holds `rssi` above the threshold and gives packets a launch time a few dozen cycles ahead. That fixes the exact cycle of expiry, which is then compared with the pulse. An immediate packet sent right behind it shows that the drained sample count left the stream aligned. Separate runs lower `rssi` during an unlimited wait, raise it during a send that is stalled by back-pressure, and change the threshold only through writes to address 0.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_TIME,
    ST_WAIT_CHAN,
    ST_SEND,
    ST_DROP
  } txs_state_e;

endpackage

// File: rtl/txs_time_base.sv
module txs_time_base #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);

  logic [TS_W-1:0] now_q;

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + TS_W'(1);
  end

  assign now = now_q;

  // R1
  time_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> now_q == $past(now_q) + TS_W'(1));

endmodule

// File: rtl/txs_cfg_regs.sv
module txs_cfg_regs #(
  parameter int              AW        = 4,
  parameter int              DW        = 12,
  parameter logic [AW-1:0]   THR_ADDR  = '0,
  parameter logic [DW-1:0]   THR_INIT  = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] thr
);

  logic [DW-1:0] thr_q;
  logic          hit;

  assign hit = we && (addr == THR_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      thr_q <= THR_INIT;
    else if (hit) thr_q <= wdata;
  end

  assign thr = thr_q;

  // R5
  thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == THR_ADDR) |=> $stable(thr_q));

endmodule

// File: rtl/txs_launch_fsm.sv
module txs_launch_fsm
  import txs_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int DL_W   = 16,
  parameter int LEN_W  = 12,
  parameter int RSSI_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [TS_W-1:0]   hdr_launch_at,
  input  logic              hdr_chan_check,
  input  logic [DL_W-1:0]   hdr_deadline,
  input  logic [LEN_W-1:0]  hdr_count,
  input  logic [TS_W-1:0]   now,
  input  logic [RSSI_W-1:0] rssi,
  input  logic [RSSI_W-1:0] thr,
  input  logic              pkt_done,
  output txs_state_e        state,
  output logic [LEN_W-1:0]  pkt_len,
  output logic              evt_sent,
  output logic              evt_expired,
  output logic              evt_late
);

  localparam logic [TS_W-1:0] TS_ASAP = '1;

  txs_state_e       state_q, state_d;
  logic [TS_W-1:0]  ts_q;
  logic             cs_q;
  logic [DL_W-1:0]  dl_q;
  logic [LEN_W-1:0] len_q;
  logic [DL_W-1:0]  wcnt_q;

  logic [TS_W-1:0]  now_next;
  logic             time_hit, time_late, chan_clear, dl_hit;
  logic             sent_ev, exp_ev, late_ev;
  logic             sent_q, exp_q, late_q;

  assign now_next   = now + TS_W'(1);
  assign time_hit   = (ts_q == TS_ASAP) || (now_next == ts_q);
  assign time_late  = (ts_q != TS_ASAP) && (now_next > ts_q);
  assign chan_clear = rssi < thr;
  assign dl_hit     = (dl_q != '0) && (wcnt_q == dl_q - DL_W'(1));

  always_comb begin
    state_d = state_q;
    sent_ev = 1'b0;
    exp_ev  = 1'b0;
    late_ev = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hdr_valid) state_d = ST_WAIT_TIME;
      end
      ST_WAIT_TIME: begin
        if (time_hit) begin
          state_d = cs_q ? ST_WAIT_CHAN : ST_SEND;
        end else if (time_late) begin
          state_d = ST_DROP;
          late_ev = 1'b1;
        end
      end
      ST_WAIT_CHAN: begin
        if (chan_clear) begin
          state_d = ST_SEND;
        end else if (dl_hit) begin
          state_d = ST_DROP;
          exp_ev  = 1'b1;
        end
      end
      ST_SEND: begin
        if (pkt_done) begin
          state_d = ST_IDLE;
          sent_ev = 1'b1;
        end
      end
      ST_DROP: begin
        if (pkt_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ts_q    <= '0;
      cs_q    <= 1'b0;
      dl_q    <= '0;
      len_q   <= '0;
      wcnt_q  <= '0;
      sent_q  <= 1'b0;
      exp_q   <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sent_q  <= sent_ev;
      exp_q   <= exp_ev;
      late_q  <= late_ev;
      if (state_q == ST_IDLE && hdr_valid) begin
        ts_q  <= hdr_launch_at;
        cs_q  <= hdr_chan_check;
        dl_q  <= hdr_deadline;
        len_q <= hdr_count;
      end
      if (state_q == ST_WAIT_CHAN) wcnt_q <= wcnt_q + DL_W'(1);
      else                         wcnt_q <= '0;
    end
  end

  assign hdr_ready   = (state_q == ST_IDLE);
  assign state       = state_q;
  assign pkt_len     = len_q;
  assign evt_sent    = sent_q;
  assign evt_expired = exp_q;
  assign evt_late    = late_q;

  // R11
  evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sent_q, exp_q, late_q}));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_CHAN && dl_q != '0) |-> wcnt_q < dl_q);

  // R3
  launch_time_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND && $past(state_q) == ST_WAIT_TIME && ts_q != TS_ASAP)
      |-> now == ts_q);

  // R6
  chan_go_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_CHAN && rssi < thr) |=> state_q == ST_SEND);

  // R9
  send_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND && !pkt_done) |=> state_q == ST_SEND);

endmodule

// File: rtl/txs_sample_path.sv
module txs_sample_path
  import txs_pkg::*;
#(
  parameter int SAMP_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  txs_state_e        state,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SAMP_W-1:0] out_data,
  output logic              out_last,
  output logic              pkt_done
);

  logic [LEN_W-1:0] cnt_q;
  logic             sending, dropping, active, xfer, at_last;

  assign sending  = (state == ST_SEND);
  assign dropping = (state == ST_DROP);
  assign active   = sending || dropping;
  assign at_last  = (cnt_q == pkt_len - LEN_W'(1));

  assign in_ready  = sending ? out_ready : dropping;
  assign out_valid = sending && in_valid;
  assign out_data  = in_data;
  assign out_last  = sending && at_last;
  assign xfer      = in_valid && in_ready;
  assign pkt_done  = active && xfer && at_last;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (pkt_done) cnt_q <= '0;
    else if (xfer)    cnt_q <= cnt_q + LEN_W'(1);
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt_q < pkt_len);

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (sending && !out_ready) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/tx_launch_sched.sv
module tx_launch_sched
  import txs_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int DL_W   = 16,
  parameter int LEN_W  = 12,
  parameter int RSSI_W = 12,
  parameter int SAMP_W = 32,
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [TS_W-1:0]   hdr_launch_at,
  input  logic              hdr_chan_check,
  input  logic [DL_W-1:0]   hdr_deadline,
  input  logic [LEN_W-1:0]  hdr_count,
  input  logic              smp_in_valid,
  output logic              smp_in_ready,
  input  logic [SAMP_W-1:0] smp_in_data,
  output logic              smp_out_valid,
  input  logic              smp_out_ready,
  output logic [SAMP_W-1:0] smp_out_data,
  output logic              smp_out_last,
  input  logic [RSSI_W-1:0] rssi,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [RSSI_W-1:0] cfg_wdata,
  output logic [TS_W-1:0]   time_now,
  output logic              evt_sent,
  output logic              evt_expired,
  output logic              evt_late
);

  logic [TS_W-1:0]   now;
  logic [RSSI_W-1:0] thr;
  txs_state_e        state;
  logic [LEN_W-1:0]  pkt_len;
  logic              pkt_done;

  txs_time_base #(.TS_W(TS_W)) u_time (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  txs_cfg_regs #(.AW(CFG_AW), .DW(RSSI_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .thr   (thr)
  );

  txs_launch_fsm #(
    .TS_W(TS_W), .DL_W(DL_W), .LEN_W(LEN_W), .RSSI_W(RSSI_W)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .hdr_valid      (hdr_valid),
    .hdr_ready      (hdr_ready),
    .hdr_launch_at  (hdr_launch_at),
    .hdr_chan_check (hdr_chan_check),
    .hdr_deadline   (hdr_deadline),
    .hdr_count      (hdr_count),
    .now            (now),
    .rssi           (rssi),
    .thr            (thr),
    .pkt_done       (pkt_done),
    .state          (state),
    .pkt_len        (pkt_len),
    .evt_sent       (evt_sent),
    .evt_expired    (evt_expired),
    .evt_late       (evt_late)
  );

  txs_sample_path #(.SAMP_W(SAMP_W), .LEN_W(LEN_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .pkt_len   (pkt_len),
    .in_valid  (smp_in_valid),
    .in_ready  (smp_in_ready),
    .in_data   (smp_in_data),
    .out_valid (smp_out_valid),
    .out_ready (smp_out_ready),
    .out_data  (smp_out_data),
    .out_last  (smp_out_last),
    .pkt_done  (pkt_done)
  );

  assign time_now = now;

  // R11
  sent_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_out_valid && smp_out_ready && smp_out_last) |=> evt_sent);

  // R8
  drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |-> !smp_out_valid);

endmodule

// File: tb/tx_launch_sched_test.sv
module tx_launch_sched_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [31:0] hdr_launch_at = '0;
  logic        hdr_chan_check = 1'b0;
  logic [15:0] hdr_deadline = '0;
  logic [11:0] hdr_count = '0;
  logic        smp_in_valid = 1'b0;
  logic        smp_in_ready;
  logic [31:0] smp_in_data = '0;
  logic        smp_out_valid;
  logic        smp_out_ready = 1'b1;
  logic [31:0] smp_out_data;
  logic        smp_out_last;
  logic [11:0] rssi = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [31:0] time_now;
  logic        evt_sent, evt_expired, evt_late;

  int total = 0;
  int bad = 0;
  bit bp_on = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  logic [31:0] q_data[$];
  bit          q_last[$];
  bit          q_first[$];
  longint      q_time[$];
  string       q_req[$];
  int          ev_kind[$];
  longint      ev_time[$];
  string       ev_req[$];
  longint      seen_first_t = -1;
  longint      last_t = -1;

  localparam logic [31:0] ASAP = 32'hFFFF_FFFF;

  always #5 clk = ~clk;

  tx_launch_sched uut (
    .clk(clk), .rst(rst),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_launch_at(hdr_launch_at), .hdr_chan_check(hdr_chan_check),
    .hdr_deadline(hdr_deadline), .hdr_count(hdr_count),
    .smp_in_valid(smp_in_valid), .smp_in_ready(smp_in_ready), .smp_in_data(smp_in_data),
    .smp_out_valid(smp_out_valid), .smp_out_ready(smp_out_ready),
    .smp_out_data(smp_out_data), .smp_out_last(smp_out_last),
    .rssi(rssi), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .time_now(time_now), .evt_sent(evt_sent), .evt_expired(evt_expired), .evt_late(evt_late)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // downstream ready, optionally throttled
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    smp_out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // monitor: pops expected samples and events
  always @(negedge clk) begin
    if (!rst) begin
      if (smp_out_valid && smp_out_ready) begin
        if (q_data.size() == 0) begin
          check("R8", "unexpected output sample", longint'(smp_out_data), -1);
        end else begin
          logic [31:0] d;
          bit          l, f;
          longint      t;
          string       r;
          d = q_data.pop_front(); l = q_last.pop_front(); f = q_first.pop_front();
          t = q_time.pop_front(); r = q_req.pop_front();
          check(r, "sample data", longint'(smp_out_data), longint'(d));
          check("R2", "last flag", longint'(smp_out_last), longint'(l));
          if (f) seen_first_t = longint'(time_now);
          if (t >= 0) check(r, "launch cycle", longint'(time_now), t);
          last_t = longint'(time_now);
        end
      end
      if (evt_sent || evt_expired || evt_late) begin
        int k;
        k = evt_sent ? 1 : (evt_expired ? 2 : 3);
        check("R11", "pulses at once", longint'(evt_sent) + evt_expired + evt_late, 1);
        if (ev_kind.size() == 0) begin
          check("R11", "unexpected pulse kind", k, 0);
        end else begin
          int     ek;
          longint et;
          string  er;
          ek = ev_kind.pop_front(); et = ev_time.pop_front(); er = ev_req.pop_front();
          check(er, "pulse kind", k, ek);
          if (ek == 1) check("R11", "sent pulse cycle", longint'(time_now), last_t + 1);
          if (et >= 0) check(er, "pulse cycle", longint'(time_now), et);
        end
      end
    end
  end

  task automatic cfg_write(input logic [3:0] a, input logic [11:0] v);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // kind: 1 sent, 2 expired, 3 late
  task automatic send_pkt(input logic [31:0] ts, input bit cs, input int dl, input int len,
                          input int id, input int kind, input longint launch_t,
                          input longint ev_t, input string req);
    for (int i = 0; i < len; i++) begin
      if (kind == 1) begin
        q_data.push_back(32'((id << 16) | i));
        q_last.push_back(i == len - 1);
        q_first.push_back(i == 0);
        q_time.push_back(i == 0 ? launch_t : -1);
        q_req.push_back(req);
      end
    end
    ev_kind.push_back(kind); ev_time.push_back(ev_t); ev_req.push_back(req);
    hdr_valid = 1'b1; hdr_launch_at = ts; hdr_chan_check = cs;
    hdr_deadline = 16'(dl); hdr_count = 12'(len);
    do @(negedge clk); while (!hdr_ready);
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      smp_in_valid = 1'b1;
      smp_in_data  = 32'((id << 16) | i);
      do @(negedge clk); while (!smp_in_ready);
      @(posedge clk); #1;
    end
    smp_in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] ts;
    logic [31:0] t0;
    longint      tr;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1", "out valid after reset", smp_out_valid, 0);
    check("R1", "hdr ready after reset", hdr_ready, 1);
    check("R1", "pulses after reset", longint'(evt_sent) + evt_expired + evt_late, 0);
    t0 = time_now;
    @(negedge clk);
    check("R1", "time step", longint'(time_now), longint'(t0) + 1);
    @(posedge clk); #1;

    // R2 immediate packet
    send_pkt(ASAP, 0, 0, 4, 1, 1, -1, -1, "R2");
    // R3 timed packet
    ts = time_now + 40;
    send_pkt(ts, 0, 0, 6, 2, 1, longint'(ts), -1, "R3");
    // R10 back-pressure during a long send
    bp_on = 1'b1;
    send_pkt(ASAP, 0, 0, 12, 3, 1, -1, -1, "R10");
    bp_on = 1'b0;
    @(posedge clk); #1;
    // R4 late packet, then R8 alignment
    send_pkt(32'd3, 0, 0, 5, 4, 3, -1, -1, "R4");
    send_pkt(ASAP, 0, 0, 3, 5, 1, -1, -1, "R8");
    // R5 / R6 threshold write and clear channel on a timed packet
    cfg_write(4'd0, 12'd100);
    rssi = 12'd50;
    ts = time_now + 30;
    send_pkt(ts, 1, 0, 5, 6, 1, longint'(ts) + 1, -1, "R6");
    // R7 deadline expiry on busy channel, then R8 alignment
    rssi = 12'd200;
    ts = time_now + 30;
    send_pkt(ts, 1, 16, 7, 7, 2, -1, longint'(ts) + 16, "R7");
    send_pkt(ASAP, 0, 0, 2, 8, 1, -1, -1, "R8");
    // R5 write elsewhere is ignored: still busy, expires
    cfg_write(4'd5, 12'd4000);
    send_pkt(ASAP, 1, 10, 4, 9, 2, -1, -1, "R5");
    // R7 deadline 0 waits until channel clears
    fork
      send_pkt(ASAP, 1, 0, 3, 10, 1, -1, -1, "R7");
      begin
        repeat (300) @(posedge clk);
        #1 rssi = 12'd40;
        tr = longint'(time_now);
      end
    join
    check("R7", "unlimited wait start", seen_first_t, tr + 1);
    // R9 send continues after rssi rises and deadline passes
    bp_on = 1'b1;
    fork
      send_pkt(ASAP, 1, 5, 24, 11, 1, -1, -1, "R9");
      begin
        repeat (12) @(posedge clk);
        #1 rssi = 12'd300;
      end
    join
    bp_on = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    check("R9", "samples left over", q_data.size(), 0);
    check("R11", "events left over", ev_kind.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule